// File: doc/BRIEF.md
# Translation Lookaside Buffer with Global Entries

This block is a small, fully associative cache of recent virtual-page to physical-frame translations. It sits in front of a page table walker. Each lookup presents a virtual page number and the kind of access being made: write, user-mode or instruction fetch. One cycle later the block answers. On a hit it returns the cached frame number and a protection-fault flag, which comes from the combined permission bits stored with the entry. On a miss it raises a walk request for that page. No table memory is read on a hit.

When the walker finishes, it returns its result on the fill port, and the block installs it. There are two ways to remove entries. An invalidate-page command removes the entry for one virtual page. A write of the address-space root register clears every entry that was installed without the global mark. Global entries stay valid across address-space switches, so shared kernel mappings do not have to be walked again after each switch.

Top module: `tlb_top`

## Requirements
- R1: A lookup of a resident page gives, on the next cycle, respValid=1, respHit=1 and the stored frame on respPfn, with walkReq=0.
- R2: A lookup of a page that is not resident gives, on the next cycle, respValid=1, respHit=0, respFault=0 and walkReq=1, with walkVpn equal to the looked-up page. walkReq is never raised for a hit or when there is no lookup.
- R3: On a hit, respFault=1 exactly when one of these holds: accWrite=1 and the writable bit is clear; accUser=1 and the user bit is clear; accExec=1 and the no-execute bit is set. A faulting hit raises no walk.
- R4: A fill makes its page resident for every lookup in later cycles. A fill of a page that is already resident replaces that entry, so only the new frame and permissions are returned.
- R5: After a cycle with rootWrite=1, every entry installed with the global bit 0 misses.
- R6: Entries installed with the global bit 1 still hit, with unchanged contents, after rootWrite.
- R7: invValid=1 removes the entry for invVpn whatever its global bit. Other entries are not affected.
- R8: A fill of a page that is not resident goes into the lowest-numbered invalid slot. When all 16 slots are valid, it goes into the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each such fill.
- R9: When a fill arrives in the same cycle as rootWrite or invValid, the fill is applied first. A non-global filled entry is therefore flushed by rootWrite, and a filled page equal to invVpn is removed.
- R10: After reset all entries are invalid, and respValid, respHit, respFault and walkReq are 0.
- R11: A lookup is compared against the contents held before that cycle's fill, invalidate or flush is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupVpn | input | 36 | Virtual page number to translate |
| accWrite | input | 1 | Access is a write |
| accUser | input | 1 | Access is from user mode |
| accExec | input | 1 | Access is an instruction fetch |
| respValid | output | 1 | Response to the previous cycle's lookup |
| respHit | output | 1 | Translation was found |
| respFault | output | 1 | Protection fault on a hit |
| respPfn | output | 40 | Physical frame number on a hit, zero otherwise |
| walkReq | output | 1 | Page walk request for a missed lookup |
| walkVpn | output | 36 | Page number to walk |
| fillValid | input | 1 | Walker result to install |
| fillVpn | input | 36 | Virtual page of the fill |
| fillPfn | input | 40 | Frame number of the fill |
| fillWritable | input | 1 | Combined writable bit |
| fillUser | input | 1 | Combined user-access bit |
| fillNoExec | input | 1 | Combined no-execute bit |
| fillGlobal | input | 1 | Entry survives root register writes |
| invValid | input | 1 | Invalidate-page command |
| invVpn | input | 36 | Page to invalidate |
| rootWrite | input | 1 | Address-space root register was written |

## Verification
Some properties are checked by the assertions on every cycle. A hit never walks and a miss always walks. A fault only comes with a hit. The walk page is the page that was looked up. No non-global entry is valid after a root write, and the global set is unchanged across a root write. Other behaviour can only be shown by the bench's scenarios, which compare against a reference model of the entry array. These are which slot a fill takes (lowest invalid slot, then the round-robin pointer), the ordering of a fill against an invalidate or flush in the same cycle, in-place refill, and the fact that a lookup sees the contents from before that cycle's updates.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VPN_W   = 36;
  parameter int PFN_W   = 40;
  parameter int ENTRIES = 16;
  localparam int IDX_W  = $clog2(ENTRIES);

  typedef struct packed {
    logic writable;
    logic user;
    logic noExec;
  } perm_t;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] pfn;
    perm_t            perm;
    logic             global;
  } entry_t;

  typedef struct packed {
    logic             fillEn;
    logic [IDX_W-1:0] fillIdx;
    logic             invEn;
    logic             flushEn;
  } strobe_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillValid,
  input  logic               invValid,
  input  logic               rootWrite,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] fillHitVec,
  output strobe_t            strobes
);
  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] matchIdx;
  logic [IDX_W-1:0] freeIdx;
  logic             anyMatch;
  logic             anyFree;
  logic             useRr;

  // Scan downward so that the lowest index wins.
  always_comb begin
    matchIdx = '0;
    freeIdx  = '0;
    anyMatch = 1'b0;
    anyFree  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fillHitVec[i]) begin
        matchIdx = IDX_W'(i);
        anyMatch = 1'b1;
      end
      if (!validVec[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
    end
  end

  assign useRr = fillValid && !anyMatch && !anyFree;

  always_comb begin
    strobes.fillEn  = fillValid;
    strobes.invEn   = invValid;
    strobes.flushEn = rootWrite;
    if (anyMatch)     strobes.fillIdx = matchIdx;
    else if (anyFree) strobes.fillIdx = freeIdx;
    else              strobes.fillIdx = rrPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (useRr) begin
      if (rrPtr == IDX_W'(ENTRIES - 1)) rrPtr <= '0;
      else                             rrPtr <= rrPtr + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic               lookupValid,
  input  logic [VPN_W-1:0]   lookupVpn,
  input  logic               accWrite,
  input  logic               accUser,
  input  logic               accExec,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [PFN_W-1:0]   fillPfn,
  input  perm_t              fillPerm,
  input  logic               fillGlobal,
  input  logic [VPN_W-1:0]   invVpn,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] fillHitVec,
  output logic [ENTRIES-1:0] globalVec,
  output logic               respValid,
  output logic               respHit,
  output logic               respFault,
  output logic [PFN_W-1:0]   respPfn,
  output logic               walkReq,
  output logic [VPN_W-1:0]   walkVpn
);
  entry_t             entries     [ENTRIES];
  entry_t             nextEntries [ENTRIES];
  logic [ENTRIES-1:0] nextValid;
  logic [ENTRIES-1:0] lookHitVec;
  logic [PFN_W-1:0]   selPfn;
  perm_t              selPerm;
  logic               hit;
  logic               fault;
  entry_t             newEntry;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : gCmp
      assign lookHitVec[g] = validVec[g] && (entries[g].vpn == lookupVpn);
      assign fillHitVec[g] = validVec[g] && (entries[g].vpn == fillVpn);
      assign globalVec[g]  = entries[g].global;
    end
  endgenerate

  always_comb begin
    selPfn  = '0;
    selPerm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookHitVec[i]) begin
        selPfn  = selPfn | entries[i].pfn;
        selPerm = perm_t'(selPerm | entries[i].perm);
      end
    end
  end

  assign hit   = |lookHitVec;
  assign fault = hit && ((accWrite && !selPerm.writable) ||
                         (accUser  && !selPerm.user)     ||
                         (accExec  &&  selPerm.noExec));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respFault <= 1'b0;
      respPfn   <= '0;
      walkReq   <= 1'b0;
      walkVpn   <= '0;
    end else begin
      respValid <= lookupValid;
      respHit   <= lookupValid && hit;
      respFault <= lookupValid && fault;
      respPfn   <= (lookupValid && hit) ? selPfn : '0;
      walkReq   <= lookupValid && !hit;
      if (lookupValid && !hit) walkVpn <= lookupVpn;
    end
  end

  assign newEntry = '{vpn: fillVpn, pfn: fillPfn, perm: fillPerm, global: fillGlobal};

  // Fill first, then invalidate, then flush.
  always_comb begin
    nextValid = validVec;
    for (int i = 0; i < ENTRIES; i++) nextEntries[i] = entries[i];
    if (strobes.fillEn) begin
      nextValid[strobes.fillIdx]   = 1'b1;
      nextEntries[strobes.fillIdx] = newEntry;
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (strobes.invEn && nextEntries[i].vpn == invVpn) nextValid[i] = 1'b0;
      if (strobes.flushEn && !nextEntries[i].global)     nextValid[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
      for (int i = 0; i < ENTRIES; i++) entries[i] <= '0;
    end else begin
      validVec <= nextValid;
      for (int i = 0; i < ENTRIES; i++) entries[i] <= nextEntries[i];
    end
  end
endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic             accWrite,
  input  logic             accUser,
  input  logic             accExec,
  output logic             respValid,
  output logic             respHit,
  output logic             respFault,
  output logic [PFN_W-1:0] respPfn,
  output logic             walkReq,
  output logic [VPN_W-1:0] walkVpn,
  input  logic             fillValid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PFN_W-1:0] fillPfn,
  input  logic             fillWritable,
  input  logic             fillUser,
  input  logic             fillNoExec,
  input  logic             fillGlobal,
  input  logic             invValid,
  input  logic [VPN_W-1:0] invVpn,
  input  logic             rootWrite
);
  strobe_t            strobes;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] fillHitVec;
  logic [ENTRIES-1:0] globalVec;
  perm_t              fillPerm;

  assign fillPerm = '{writable: fillWritable, user: fillUser, noExec: fillNoExec};

  tlb_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .fillValid(fillValid), .invValid(invValid),
    .rootWrite(rootWrite), .validVec(validVec), .fillHitVec(fillHitVec),
    .strobes(strobes)
  );

  tlb_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .accWrite(accWrite), .accUser(accUser), .accExec(accExec),
    .fillVpn(fillVpn), .fillPfn(fillPfn), .fillPerm(fillPerm),
    .fillGlobal(fillGlobal), .invVpn(invVpn),
    .validVec(validVec), .fillHitVec(fillHitVec), .globalVec(globalVec),
    .respValid(respValid), .respHit(respHit), .respFault(respFault),
    .respPfn(respPfn), .walkReq(walkReq), .walkVpn(walkVpn)
  );
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
  import tlb_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               lookupValid,
  input logic [VPN_W-1:0]   lookupVpn,
  input logic               respValid,
  input logic               respHit,
  input logic               respFault,
  input logic               walkReq,
  input logic [VPN_W-1:0]   walkVpn,
  input logic               fillValid,
  input logic               invValid,
  input logic               rootWrite,
  input logic [ENTRIES-1:0] validVec,
  input logic [ENTRIES-1:0] globalVec
);
  // R1
  hit_no_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respHit |-> !walkReq);

  // R2
  miss_walks_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid && !respHit |-> walkReq);

  // R2
  walk_needs_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
    walkReq |-> respValid);

  // R2
  walk_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> (respValid && (!walkReq || walkVpn == $past(lookupVpn))));

  // R3
  fault_on_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    respFault |-> (respValid && respHit));

  // R5
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    rootWrite && !fillValid |=> ((validVec & ~globalVec) == '0));

  // R6
  global_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    rootWrite && !fillValid && !invValid |=>
      ((validVec & globalVec) == $past(validVec & globalVec)));
endmodule

bind tlb_top tlb_chk i_chk (.*);

// File: tb/test_tlb_top.sv
`timescale 1ns/1ps
module test_tlb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rstN;
  logic        lookupValid, accWrite, accUser, accExec;
  logic [35:0] lookupVpn;
  logic        respValid, respHit, respFault, walkReq;
  logic [39:0] respPfn;
  logic [35:0] walkVpn;
  logic        fillValid, fillWritable, fillUser, fillNoExec, fillGlobal;
  logic [35:0] fillVpn;
  logic [39:0] fillPfn;
  logic        invValid, rootWrite;
  logic [35:0] invVpn;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  // Reference model of the entry array
  bit          mValid [N];
  logic [35:0] mVpn   [N];
  logic [39:0] mPfn   [N];
  logic [2:0]  mPerm  [N]; // {writable, user, noExec}
  bit          mGlob  [N];
  int          mRr;

  always #2 clk = ~clk;

  tlb_top i_tlb_top (.*);

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int findVpn(logic [35:0] v);
    for (int i = 0; i < N; i++) if (mValid[i] && mVpn[i] == v) return i;
    return -1;
  endfunction

  task automatic modelUpdate();
    if (fillValid) begin
      int idx = findVpn(fillVpn);
      if (idx < 0) for (int i = N - 1; i >= 0; i--) if (!mValid[i]) idx = i;
      if (idx < 0) begin idx = mRr; mRr = (mRr + 1) % N; end
      mValid[idx] = 1; mVpn[idx] = fillVpn; mPfn[idx] = fillPfn;
      mPerm[idx] = {fillWritable, fillUser, fillNoExec}; mGlob[idx] = fillGlobal;
    end
    for (int i = 0; i < N; i++) begin
      if (invValid && mVpn[i] == invVpn) mValid[i] = 0;
      if (rootWrite && !mGlob[i]) mValid[i] = 0;
    end
  endtask

  task automatic clearIn();
    lookupValid = 0; lookupVpn = '0; accWrite = 0; accUser = 0; accExec = 0;
    fillValid = 0; fillVpn = '0; fillPfn = '0; fillWritable = 0; fillUser = 0;
    fillNoExec = 0; fillGlobal = 0; invValid = 0; invVpn = '0; rootWrite = 0;
  endtask

  // One clock: inputs already driven at a falling edge
  task automatic cycle();
    int  idx   = findVpn(lookupVpn); // R11: pre-update contents
    bit  lv    = lookupValid;
    bit  eHit  = lv && idx >= 0;
    bit  eFlt  = 0;
    logic [39:0] ePfn = '0;
    logic [35:0] eVpn = lookupVpn;
    if (eHit) begin
      ePfn = mPfn[idx];
      eFlt = (accWrite && !mPerm[idx][2]) || (accUser && !mPerm[idx][1]) ||
             (accExec && mPerm[idx][0]);
    end
    modelUpdate();
    @(posedge clk);
    @(negedge clk);
    chk(respValid == lv, "R1 respValid", 64'(respValid), 64'(lv));
    if (lv && eHit) begin
      chk(respHit == 1, "R1 hit", 64'(respHit), 1);
      chk(respPfn == ePfn, "R1 frame", 64'(respPfn), 64'(ePfn));
      chk(walkReq == 0, "R1 no walk", 64'(walkReq), 0);
      chk(respFault == eFlt, "R3 fault", 64'(respFault), 64'(eFlt));
    end else if (lv) begin
      chk(respHit == 0, "R2 miss", 64'(respHit), 0);
      chk(walkReq == 1, "R2 walk", 64'(walkReq), 1);
      chk(walkVpn == eVpn, "R2 walk page", 64'(walkVpn), 64'(eVpn));
      chk(respFault == 0, "R2 no fault", 64'(respFault), 0);
    end else begin
      chk(walkReq == 0, "R2 idle walk", 64'(walkReq), 0);
    end
    clearIn();
  endtask

  task automatic look(logic [35:0] v, bit w, bit u, bit x);
    lookupValid = 1; lookupVpn = v; accWrite = w; accUser = u; accExec = x;
    cycle();
  endtask

  task automatic setFill(logic [35:0] v, logic [39:0] p, bit w, bit u, bit nx, bit gl);
    fillValid = 1; fillVpn = v; fillPfn = p;
    fillWritable = w; fillUser = u; fillNoExec = nx; fillGlobal = gl;
  endtask

  task automatic fill(logic [35:0] v, logic [39:0] p, bit w, bit u, bit nx, bit gl);
    setFill(v, p, w, u, nx, gl);
    cycle();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    clearIn();
    for (int i = 0; i < N; i++) begin mValid[i] = 0; mGlob[i] = 0; end
    mRr = 0;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R10: reset state at the ports
    chk(respValid == 0, "R10 respValid", 64'(respValid), 0);
    chk(respHit == 0, "R10 respHit", 64'(respHit), 0);
    chk(respFault == 0, "R10 respFault", 64'(respFault), 0);
    chk(walkReq == 0, "R10 walkReq", 64'(walkReq), 0);

    // R10 / R2: empty after reset, miss walks
    look(36'h1_0000_000A, 0, 0, 0);
    // R4: fill then hit
    fill(36'h1_0000_000A, 40'hAA_0000_1111, 1, 1, 0, 0);
    look(36'h1_0000_000A, 1, 1, 0);
    // R3: read-only, kernel, no-exec global entry
    fill(36'h2_0000_000B, 40'hBB_0000_2222, 0, 0, 1, 1);
    look(36'h2_0000_000B, 1, 0, 0);
    look(36'h2_0000_000B, 0, 1, 0);
    look(36'h2_0000_000B, 0, 0, 1);
    look(36'h2_0000_000B, 0, 0, 0);
    // R5 / R6: root write flushes non-global only
    rootWrite = 1; cycle();
    look(36'h1_0000_000A, 0, 0, 0);
    look(36'h2_0000_000B, 0, 0, 0);
    // R7: invalidate removes a global entry too
    invValid = 1; invVpn = 36'h2_0000_000B; cycle();
    look(36'h2_0000_000B, 0, 0, 0);
    // R9: same-cycle ordering
    setFill(36'h3_0000_000D, 40'hDD, 1, 1, 0, 0); rootWrite = 1; cycle();
    look(36'h3_0000_000D, 0, 0, 0);
    setFill(36'h3_0000_000E, 40'hEE, 1, 1, 0, 1); rootWrite = 1; cycle();
    look(36'h3_0000_000E, 0, 0, 0);
    setFill(36'h3_0000_000F, 40'hFF, 1, 1, 0, 0); invValid = 1; invVpn = 36'h3_0000_000F; cycle();
    look(36'h3_0000_000F, 0, 0, 0);
    invValid = 1; invVpn = 36'h3_0000_000E; cycle();
    // R8: fill all slots, then overflow through the round-robin pointer
    for (int i = 0; i < N + 3; i++) fill(36'h4_0000_0000 + 36'(i), 40'h100 + 40'(i), 1, 1, 0, 0);
    for (int i = 0; i < N + 3; i++) look(36'h4_0000_0000 + 36'(i), 0, 0, 0);
    // R8: a freed slot is reused before the pointer
    invValid = 1; invVpn = 36'h4_0000_0005; cycle();
    fill(36'h4_0000_0050, 40'h550, 1, 1, 0, 0);
    look(36'h4_0000_0050, 0, 0, 0);
    // R4: refill in place replaces the frame
    fill(36'h4_0000_0050, 40'h777, 0, 1, 0, 0);
    look(36'h4_0000_0050, 1, 1, 0);
    // R11: lookup in the same cycle as its fill misses, next cycle hits
    setFill(36'h6_0000_0001, 40'h601, 1, 1, 0, 0);
    lookupValid = 1; lookupVpn = 36'h6_0000_0001; cycle();
    look(36'h6_0000_0001, 0, 0, 0);

    // Random mix over a small page pool
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 100 < 70) begin
        lookupValid = 1; lookupVpn = 36'h5_0000_0000 + 36'($urandom % 24);
        accWrite = 1'($urandom); accUser = 1'($urandom); accExec = 1'($urandom);
      end
      if ($urandom % 100 < 30)
        setFill(36'h5_0000_0000 + 36'($urandom % 24), {8'($urandom), 32'($urandom)},
                1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
      if ($urandom % 100 < 5) begin
        invValid = 1; invVpn = 36'h5_0000_0000 + 36'($urandom % 24);
      end
      if ($urandom % 100 < 3) rootWrite = 1;
      cycle();
    end
    finishRun();
  end
endmodule